// File: doc/BRIEF.md
# Non-Critical Fault Collector with Test Injection

The block gathers fault indications from a set of hardware sources (32 by default) into sticky status flags. From these flags it drives two reaction lines, a lower-severity alarm and a non-maskable interrupt (NMI), and a single combined interrupt request. Software reaches the block through a simple register bus. It picks, per source, which reaction an unmasked fault raises and clears fault flags by writing ones. It can also make one source look faulty by writing that source's index to a write-only injection register. The fake fault enters on the same wire as the real one, so a test covers the whole path from status flag to reaction pin.

A per-source reaction mask input stops a source from driving any reaction while leaving its status flag recorded. A configuration window timer also runs. The window opens at reset, or when software writes the open register. If software does not close it within a set number of cycles, a time-out flag is raised. The interrupt status word holds this flag next to the live alarm and NMI lines, and each of the three has its own enable.

All bus accesses complete in a single cycle with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational while `bus_rd` is high, and is zero otherwise. The fault inputs, the mask and the outputs are plain level signals with no handshake.

Register offsets:

| Offset | Register | Access |
|---|---|---|
| 0x00 | fault status, bit n = source n | read / write-one-to-clear |
| 0x04 | injection code | write-only |
| 0x08 | alarm select, bit n = source n | read/write |
| 0x0C | NMI select, bit n = source n | read/write |
| 0x10 | interrupt status | bit0 read / write-one-to-clear, bits 1–2 read-only |
| 0x14 | interrupt enable, bits 2:0 | read/write |
| 0x18 | window close | write, any data |
| 0x1C | window open | write, any data |

In the interrupt status word, bit0 is the time-out flag, bit1 is the alarm line and bit2 is the NMI line. The interrupt enable register uses the same bit positions.

Top module: `fcol_top`

## Requirements
- R1: After reset, all fault status bits, both select registers, the interrupt enables and the time-out flag read as 0, and `alarm_o`, `nmi_o` and `irq_o` are low.
- R2: A high level on `fault_in[n]` at a clock edge sets fault status bit n at that edge. The bit stays set after the input falls.
- R3: Writing a code v in 0..31 to offset 0x04 sets only fault status bit v, one cycle after the write edge. The status path is the same one a real fault on source v uses.
- R4: Writing a code of 32 or more to offset 0x04 leaves every fault status bit unchanged.
- R5: Reading offset 0x04 always returns 0.
- R6: Writing to offset 0x00 clears exactly the status bits written as 1. If a source is faulting in the same cycle that its bit is cleared, the bit stays set.
- R7: `nmi_o` is high when some status bit n is set with `react_mask[n]` low and NMI select bit n set. `alarm_o` is high when some such bit has alarm select set and NMI select clear, so NMI takes priority.
- R8: A source with `react_mask[n]` high still sets its status bit, but drives neither `alarm_o` nor `nmi_o`.
- R9: Interrupt status bits 1 and 2 follow `alarm_o` and `nmi_o` live. They fall once the causing status bits are cleared, and writes to them have no effect.
- R10: If the configuration window is not closed within 255 cycles of reset or of a write to offset 0x1C, interrupt status bit0 sets. Writing 1 to bit0 clears it. Closing the window in time keeps bit0 at 0.
- R11: `irq_o` is high exactly when some interrupt status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 8 | register byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid while bus_rd is high |
| fault_in | input | 32 | real fault indications, one per source |
| react_mask | input | 32 | 1 suppresses the reaction of that source |
| alarm_o | output | 1 | alarm reaction line |
| nmi_o | output | 1 | NMI reaction line |
| irq_o | output | 1 | combined interrupt request |

## Verification
A status flag that is lost, stuck or set on the wrong source shows on the next read of offset 0x00. When the source is unmasked and selected, it also shows on `alarm_o` or `nmi_o` in the same cycle, because both lines are decoded combinationally from the flags. A fault in the injection decoder shows one cycle after the write: the wrong status bit is set, or a bit is set for a code above 31. The time-out flag is checked on both sides of its window, once after a timely close and once after the window expires, and `irq_o` is compared against each combination of enable and status.

// File: rtl/fcol_pkg.sv
package fcol_pkg;
  localparam int unsigned FCOL_AW = 8;

  typedef enum logic [FCOL_AW-1:0] {
    A_FSTAT  = 8'h00,
    A_INJ    = 8'h04,
    A_ALMSEL = 8'h08,
    A_NMISEL = 8'h0C,
    A_ISTAT  = 8'h10,
    A_IEN    = 8'h14,
    A_CLOSE  = 8'h18,
    A_OPEN   = 8'h1C
  } fcol_addr_e;

  localparam int unsigned IRQ_TMO = 0;
  localparam int unsigned IRQ_ALM = 1;
  localparam int unsigned IRQ_NMI = 2;
  localparam int unsigned IRQ_W   = 3;
endpackage

// File: rtl/fcol_inject_dec.sv
module fcol_inject_dec #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  code,
  output logic [NUM_SRC-1:0] pulse
);
  // one flop per source; a code outside the range matches none
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    always_ff @(posedge clk) begin
      if (!rst_n) pulse[g] <= 1'b0;
      else        pulse[g] <= wr_en && (code == DATA_W'(g));
    end
  end
endmodule

// File: rtl/fcol_status_bank.sv
module fcol_status_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] fault_in,
  input  logic [NUM_SRC-1:0] inj_pulse,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] stat_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic raw;
    assign raw = fault_in[g] | inj_pulse[g];
    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else        stat_q[g] <= raw | (stat_q[g] & ~(clr_en & clr_bits[g]));
    end
  end
endmodule

// File: rtl/fcol_cfg_timer.sv
module fcol_cfg_timer #(
  parameter int unsigned TMO_CYCLES = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_wr,
  input  logic close_wr,
  input  logic clr_wr,
  output logic tmo_q
);
  localparam int unsigned CNT_W = $clog2(TMO_CYCLES + 1);
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      if (clr_wr) tmo_q <= 1'b0;
      if (open_wr) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
      end else if (close_wr) begin
        open_q <= 1'b0;
      end else if (open_q) begin
        if (cnt_q == CNT_W'(TMO_CYCLES - 1)) begin
          open_q <= 1'b0;
          tmo_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fcol_react.sv
module fcol_react #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] stat,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] alm_sel,
  input  logic [NUM_SRC-1:0] nmi_sel,
  output logic               alarm,
  output logic               nmi
);
  logic [NUM_SRC-1:0] live;
  always_comb begin
    live  = stat & ~mask;
    nmi   = |(live & nmi_sel);
    alarm = |(live & alm_sel & ~nmi_sel);
  end
endmodule

// File: rtl/fcol_top.sv
module fcol_top
  import fcol_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned TMO_CYCLES = 255
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [FCOL_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] fault_in,
  input  logic [NUM_SRC-1:0] react_mask,
  output logic               alarm_o,
  output logic               nmi_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] stat_q, inj_vec, alm_sel_q, nmi_sel_q;
  logic [IRQ_W-1:0]   ien_q, istat;
  logic               tmo_q;
  logic               wr_fstat, wr_inj, wr_istat;

  assign wr_fstat = bus_wr && (bus_addr == A_FSTAT);
  assign wr_inj   = bus_wr && (bus_addr == A_INJ);
  assign wr_istat = bus_wr && (bus_addr == A_ISTAT);

  fcol_inject_dec #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_inj (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_inj), .code(bus_wdata), .pulse(inj_vec));

  fcol_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .inj_pulse(inj_vec),
    .clr_en(wr_fstat), .clr_bits(bus_wdata[NUM_SRC-1:0]), .stat_q(stat_q));

  fcol_cfg_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .open_wr(bus_wr && (bus_addr == A_OPEN)),
    .close_wr(bus_wr && (bus_addr == A_CLOSE)),
    .clr_wr(wr_istat && bus_wdata[IRQ_TMO]),
    .tmo_q(tmo_q));

  fcol_react #(.NUM_SRC(NUM_SRC)) u_react (
    .stat(stat_q), .mask(react_mask), .alm_sel(alm_sel_q), .nmi_sel(nmi_sel_q),
    .alarm(alarm_o), .nmi(nmi_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_sel_q <= '0;
      nmi_sel_q <= '0;
      ien_q     <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_ALMSEL) alm_sel_q <= bus_wdata[NUM_SRC-1:0];
      if (bus_addr == A_NMISEL) nmi_sel_q <= bus_wdata[NUM_SRC-1:0];
      if (bus_addr == A_IEN)    ien_q     <= bus_wdata[IRQ_W-1:0];
    end
  end

  always_comb begin
    istat          = '0;
    istat[IRQ_TMO] = tmo_q;
    istat[IRQ_ALM] = alarm_o;
    istat[IRQ_NMI] = nmi_o;
  end
  assign irq_o = |(istat & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_FSTAT:  bus_rdata = DATA_W'(stat_q);
        A_ALMSEL: bus_rdata = DATA_W'(alm_sel_q);
        A_NMISEL: bus_rdata = DATA_W'(nmi_sel_q);
        A_ISTAT:  bus_rdata = DATA_W'(istat);
        A_IEN:    bus_rdata = DATA_W'(ien_q);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcol_checks.sv
module fcol_checks
  import fcol_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [FCOL_AW-1:0] bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_SRC-1:0] fault_in,
  input logic [NUM_SRC-1:0] react_mask,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] inj_vec,
  input logic [IRQ_W-1:0]   ien_q,
  input logic               alarm_o,
  input logic               nmi_o,
  input logic               irq_o
);
  assert_fault_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(fault_in)) == $past(fault_in)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_FSTAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_inject_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_INJ && bus_wdata < DATA_W'(NUM_SRC)) |=> ($countones(inj_vec) == 1));

  assert_inject_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_INJ && bus_wdata >= DATA_W'(NUM_SRC)) |=> (inj_vec == '0));

  assert_inj_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_INJ) |-> (bus_rdata == '0));

  assert_quiet_when_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> (!alarm_o && !nmi_o));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (react_mask == '1) |-> (!alarm_o && !nmi_o));

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_o);
endmodule

bind fcol_top fcol_checks #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_fcol_checks (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in),
  .react_mask(react_mask), .stat_q(stat_q), .inj_vec(inj_vec), .ien_q(ien_q),
  .alarm_o(alarm_o), .nmi_o(nmi_o), .irq_o(irq_o));

// File: tb/fcol_top_bench.sv
module fcol_top_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0] O_FSTAT = 8'h00, O_INJ = 8'h04, O_ALM = 8'h08, O_NMI = 8'h0C,
                         O_ISTAT = 8'h10, O_IEN = 8'h14, O_CLOSE = 8'h18, O_OPEN = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] fault_in = '0, react_mask = '0;
  logic        alarm_o, nmi_o, irq_o;

  int checks = 0, fails = 0;
  logic [31:0] e_stat = '0, e_alm = '0, e_nmi = '0;
  logic [2:0]  e_ien = '0;
  logic        e_tmo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcol_top u_fcol_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in),
    .react_mask(react_mask), .alarm_o(alarm_o), .nmi_o(nmi_o), .irq_o(irq_o));

  function automatic logic f_nmi();
    return |(e_stat & ~react_mask & e_nmi);
  endfunction
  function automatic logic f_alarm();
    return |(e_stat & ~react_mask & e_alm & ~e_nmi);
  endfunction
  function automatic logic f_irq();
    return (e_tmo & e_ien[0]) | (f_alarm() & e_ien[1]) | (f_nmi() & e_ien[2]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check_outs(string req);
    logic [31:0] v;
    rd(O_FSTAT, v);
    chk(req, v, e_stat);
    chk({req, " alarm"}, {31'd0, alarm_o}, {31'd0, f_alarm()});
    chk({req, " nmi"}, {31'd0, nmi_o}, {31'd0, f_nmi()});
    chk({req, " irq R11"}, {31'd0, irq_o}, {31'd0, f_irq()});
  endtask

  task automatic inject(logic [31:0] code);
    wr(O_INJ, code);
    @(negedge clk);
    if (code < 32) e_stat[code[4:0]] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0F17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(O_FSTAT, v);  chk("R1 fstat", v, 0);
    rd(O_ALM, v);    chk("R1 almsel", v, 0);
    rd(O_NMI, v);    chk("R1 nmisel", v, 0);
    rd(O_IEN, v);    chk("R1 ien", v, 0);
    rd(O_ISTAT, v);  chk("R1 istat", v, 0);
    chk("R1 outs", {29'd0, alarm_o, nmi_o, irq_o}, 0);
    wr(O_CLOSE, 0);
    // R2 real fault sticky
    fault_in = 32'h0000_0010; @(negedge clk); fault_in = '0;
    e_stat[4] = 1'b1;
    repeat (2) @(negedge clk);
    check_outs("R2 sticky");
    // R3 injection at edges of the range
    inject(0);  check_outs("R3 code0");
    inject(31); check_outs("R3 code31");
    // R4 out-of-range codes
    inject(32); inject(8'hFF); inject(32'h8000_0001);
    check_outs("R4 no inject");
    // R5 read of injection register
    rd(O_INJ, v); chk("R5", v, 0);
    // R6 write-one-to-clear, partial
    wr(O_FSTAT, 32'h8000_0000); e_stat[31] = 1'b0;
    check_outs("R6 partial clear");
    // R6 set wins over clear
    fault_in = 32'h1; bus_wr = 1'b1; bus_addr = O_FSTAT; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 1'b0; fault_in = '0;
    check_outs("R6 set wins");
    // R7 NMI priority
    wr(O_ALM, 32'h0000_0011); e_alm = 32'h11;
    wr(O_NMI, 32'h0000_0010); e_nmi = 32'h10;
    wr(O_IEN, 3'b110);        e_ien = 3'b110;
    check_outs("R7 nmi priority");
    chk("R7 nmi high", {31'd0, nmi_o}, 1);
    // R8 masked reaction
    react_mask = 32'h0000_0011; #1;
    check_outs("R8 masked");
    chk("R8 nmi low", {31'd0, nmi_o}, 0);
    inject(9); check_outs("R8 status still sets");
    react_mask = '0;
    // R9 live mirror and fall after clear
    rd(O_ISTAT, v); chk("R9 istat", v, {29'd0, f_nmi(), f_alarm(), e_tmo});
    wr(O_ISTAT, 32'h6);
    rd(O_ISTAT, v); chk("R9 write ignored", v, {29'd0, f_nmi(), f_alarm(), e_tmo});
    wr(O_FSTAT, 32'hFFFF_FFFF); e_stat = '0;
    rd(O_ISTAT, v); chk("R9 fall", v, 0);
    // random phase
    for (int i = 0; i < 150; i++) begin
      logic [31:0] r;
      r = $urandom;
      case (r % 6)
        0: begin
          fault_in = $urandom & $urandom & $urandom; e_stat |= fault_in;
          @(negedge clk); fault_in = '0;
        end
        1: inject($urandom % 48);
        2: begin v = $urandom; wr(O_FSTAT, v); e_stat &= ~v; end
        3: begin v = $urandom; wr(O_ALM, v); e_alm = v; end
        4: begin v = $urandom; wr(O_NMI, v); e_nmi = v; end
        default: begin
          react_mask = $urandom | $urandom;
          v = $urandom; wr(O_IEN, v); e_ien = v[2:0];
        end
      endcase
      check_outs("R2 R3 R6 R7 R8 random");
    end
    // R10 time-out
    wr(O_IEN, 3'b001); e_ien = 3'b001;
    wr(O_OPEN, 0);
    repeat (100) @(negedge clk);
    rd(O_ISTAT, v); chk("R10 not yet", {31'd0, v[0]}, 0);
    repeat (200) @(negedge clk);
    e_tmo = 1'b1;
    rd(O_ISTAT, v); chk("R10 expired", {31'd0, v[0]}, 1);
    chk("R11 tmo irq", {31'd0, irq_o}, {31'd0, f_irq()});
    wr(O_ISTAT, 1); e_tmo = 1'b0;
    rd(O_ISTAT, v); chk("R10 cleared", {31'd0, v[0]}, 0);
    chk("R11 irq low", {31'd0, irq_o}, {31'd0, f_irq()});
    wr(O_OPEN, 0);
    repeat (200) @(negedge clk);
    wr(O_CLOSE, 0);
    repeat (200) @(negedge clk);
    rd(O_ISTAT, v); chk("R10 closed in time", {31'd0, v[0]}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule